// File: doc/BRIEF.md
# Tachometer Speed Discriminator with Lock Window

This block holds a motor at a constant speed against a crystal reference. A tachometer edge arrives as a one-cycle `fg_pulse`. A prescaled reference arrives as a one-cycle `ref_tick` enable. The block counts reference ticks across one tachometer period and compares the count with a target of BASE or 2·BASE ticks. The `short_count` input picks the target. From that comparison it sets a speed-direction output and an active-low in-lock flag. The analog loop filter downstream integrates both signals into a drive level.

The period counter works on alternate tachometer periods. One pulse opens a measurement and the next pulse closes it. The pulse after that opens a new one, so a verdict comes out once every two tachometer periods. Alongside the counter, a free-running reference divider emits one mark every target's worth of ticks. At every tachometer pulse the divider's position is sampled, which gives a phase verdict once per period.

Top module: `spd_discriminator`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `accel` is 0, `lock_n` is 1, `phase_late` is 0 and `ref_mark` is 0.
- R2: The target T is BASE when `short_count` is 1 and 2·BASE when it is 0. The value of `short_count` in the cycle of the closing pulse decides the target for that verdict.
- R3: After reset, the 1st, 3rd, 5th … `fg_pulse` each open a measurement and leave `accel` and `lock_n` unchanged. The 2nd, 4th … pulses close it. The measured count M is the number of cycles with `ref_tick` high, from the cycle after the opening pulse through the cycle of the closing pulse.
- R4: After a closing pulse, `accel` becomes 1 if M > T and 0 if M ≤ T.
- R5: After a closing pulse, `lock_n` becomes 0 if |M − T| ≤ T/16 and 1 otherwise. With BASE = 64 the window is ±4 counts for T = 64 and ±8 counts for T = 128.
- R6: M saturates at 2·T. A period with more ticks than that reads as 2·T, which gives `accel` = 1 and `lock_n` = 1.
- R7: `accel` and `lock_n` take their new values in the second clock cycle after the cycle in which the closing pulse is sampled. At all other times they hold.
- R8: A reference position counter advances on each `ref_tick` and wraps to 0 from T−1 or above. `ref_mark` is 1 for exactly the one cycle after each wrapping tick.
- R9: On every `fg_pulse`, `phase_late` takes the value 1 if the reference position counter is below T/2 in that cycle, and 0 otherwise. The position is read before that cycle's tick is applied. The new value appears the next cycle and holds until the next pulse.
- R10: Cycles with `ref_tick` low add nothing to M or to the reference position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | One-cycle enable from the prescaled crystal reference |
| fg_pulse | input | 1 | One-cycle synchronized tachometer edge |
| short_count | input | 1 | 1 selects target BASE, 0 selects 2·BASE |
| accel | output | 1 | 1 requests acceleration (period too long) |
| lock_n | output | 1 | 0 when the last measured period is inside the lock window |
| ref_mark | output | 1 | Reference pulse train, one pulse per T ticks |
| phase_late | output | 1 | 1 when the tachometer edge lags the reference mark |

## Verification
The bench builds the block with BASE = 64, so T is 64 or 128 and the lock windows are ±4 and ±8 counts. At that size a test can place a period exactly on each window edge and one count past it, for both targets. A stalled period of three targets can reach the saturation limit. Several hundred random periods with sparse ticks and changes of target mid-flight also fit in a short run. Every cycle compares all four outputs against a model built from the requirements.

// File: rtl/spd_pkg.sv
package spd_pkg;

    typedef enum logic {
        MTR_IDLE  = 1'b0,
        MTR_COUNT = 1'b1
    } mtr_state_e;

    typedef struct packed {
        logic accel;
        logic locked;
    } verdict_t;

    function automatic int spd_target(input int base, input logic short_sel);
        return short_sel ? base : 2 * base;
    endfunction

    function automatic int spd_limit(input int base, input logic short_sel);
        return 2 * spd_target(base, short_sel);
    endfunction

    function automatic int spd_window(input int target);
        return target >> 4;
    endfunction

endpackage

// File: rtl/spd_period_meter.sv
module spd_period_meter
    import spd_pkg::*;
#(
    parameter int BASE = 512,
    parameter int CW   = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          fg,
    input  logic          short_sel,
    output logic          meas_valid,
    output logic [CW-1:0] meas_count,
    output logic          meas_short
);
    localparam int CWP1 = CW + 1;

    mtr_state_e    state;
    logic [CW-1:0] cnt;
    logic [CW:0]   lim;
    logic [CW:0]   sum;
    logic [CW-1:0] closed;

    always_comb begin
        lim    = CWP1'(spd_limit(BASE, short_sel));
        sum    = {1'b0, cnt} + CWP1'(tick);
        closed = (sum > lim) ? lim[CW-1:0] : sum[CW-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= MTR_IDLE;
            cnt        <= '0;
            meas_valid <= 1'b0;
            meas_count <= '0;
            meas_short <= 1'b1;
        end else begin
            meas_valid <= 1'b0;
            case (state)
                MTR_IDLE: begin
                    if (fg) begin
                        state <= MTR_COUNT;
                        cnt   <= '0;
                    end
                end
                MTR_COUNT: begin
                    if (fg) begin
                        state      <= MTR_IDLE;
                        meas_valid <= 1'b1;
                        meas_count <= closed;
                        meas_short <= short_sel;
                    end else if (tick && ({1'b0, cnt} < lim)) begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= MTR_IDLE;
            endcase
        end
    end

    // R6: a closed measurement never exceeds twice its target
    assert_sat_limit_R6: assert property (@(posedge clk) disable iff (rst)
        meas_valid |-> ({1'b0, meas_count} <= CWP1'(spd_limit(BASE, meas_short))));

    // R3: a closing pulse is always followed by an opening one
    assert_alternate_R3: assert property (@(posedge clk) disable iff (rst)
        meas_valid |=> !meas_valid);

endmodule

// File: rtl/spd_judge.sv
module spd_judge
    import spd_pkg::*;
#(
    parameter int BASE = 512,
    parameter int CW   = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          valid_i,
    input  logic [CW-1:0] count_i,
    input  logic          short_i,
    output logic          accel_o,
    output logic          lock_n_o
);
    localparam int CWP1 = CW + 1;

    logic [CW:0] tgt;
    logic [CW:0] win;
    logic [CW:0] cnt_w;
    logic [CW:0] diff;
    verdict_t    vd;

    always_comb begin
        tgt   = CWP1'(spd_target(BASE, short_i));
        win   = CWP1'(spd_window(spd_target(BASE, short_i)));
        cnt_w = {1'b0, count_i};
        diff  = (cnt_w >= tgt) ? (cnt_w - tgt) : (tgt - cnt_w);
        vd.accel  = cnt_w > tgt;
        vd.locked = diff <= win;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            accel_o  <= 1'b0;
            lock_n_o <= 1'b1;
        end else if (valid_i) begin
            accel_o  <= vd.accel;
            lock_n_o <= !vd.locked;
        end
    end

    // R7: the lock flag moves only right after a verdict
    assert_lock_on_eval_R7: assert property (@(posedge clk) disable iff (rst)
        !$stable(lock_n_o) |-> $past(valid_i));

    // R7: the direction output moves only right after a verdict
    assert_accel_on_eval_R7: assert property (@(posedge clk) disable iff (rst)
        !$stable(accel_o) |-> $past(valid_i));

endmodule

// File: rtl/spd_ref_phase.sv
module spd_ref_phase
    import spd_pkg::*;
#(
    parameter int BASE = 512,
    parameter int CW   = 12
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic fg,
    input  logic short_sel,
    output logic mark_o,
    output logic phase_o
);
    localparam int CWP1 = CW + 1;

    logic [CW-1:0] pos;
    logic [CW:0]   tgt;
    logic          at_end;
    logic          early_half;

    always_comb begin
        tgt        = CWP1'(spd_target(BASE, short_sel));
        at_end     = ({1'b0, pos} >= (tgt - 1'b1));
        early_half = ({1'b0, pos} < (tgt >> 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos     <= '0;
            mark_o  <= 1'b0;
            phase_o <= 1'b0;
        end else begin
            mark_o <= tick && at_end;
            if (tick) begin
                pos <= at_end ? '0 : pos + 1'b1;
            end
            if (fg) begin
                phase_o <= early_half;
            end
        end
    end

    // R8: every mark comes from a tick
    assert_mark_from_tick_R8: assert property (@(posedge clk) disable iff (rst)
        mark_o |-> $past(tick));

    // R8: marks are single-cycle
    assert_mark_single_R8: assert property (@(posedge clk) disable iff (rst)
        mark_o |=> !mark_o);

    // R9: phase verdict changes only after a tachometer pulse
    assert_phase_on_fg_R9: assert property (@(posedge clk) disable iff (rst)
        !$stable(phase_o) |-> $past(fg));

endmodule

// File: rtl/spd_discriminator.sv
module spd_discriminator
    import spd_pkg::*;
#(
    parameter int BASE = 512
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_tick,
    input  logic fg_pulse,
    input  logic short_count,
    output logic accel,
    output logic lock_n,
    output logic ref_mark,
    output logic phase_late
);
    localparam int N_LONG = 2 * BASE;
    localparam int CW     = $clog2(2 * N_LONG + 1);

    logic          m_valid;
    logic [CW-1:0] m_count;
    logic          m_short;

    spd_period_meter #(.BASE(BASE), .CW(CW)) u_meter (
        .clk        (clk),
        .rst        (rst),
        .tick       (ref_tick),
        .fg         (fg_pulse),
        .short_sel  (short_count),
        .meas_valid (m_valid),
        .meas_count (m_count),
        .meas_short (m_short)
    );

    spd_judge #(.BASE(BASE), .CW(CW)) u_judge (
        .clk      (clk),
        .rst      (rst),
        .valid_i  (m_valid),
        .count_i  (m_count),
        .short_i  (m_short),
        .accel_o  (accel),
        .lock_n_o (lock_n)
    );

    spd_ref_phase #(.BASE(BASE), .CW(CW)) u_ref (
        .clk       (clk),
        .rst       (rst),
        .tick      (ref_tick),
        .fg        (fg_pulse),
        .short_sel (short_count),
        .mark_o    (ref_mark),
        .phase_o   (phase_late)
    );

    // R1: outputs sit at their idle values in the cycle after reset
    assert_reset_idle_R1: assert property (@(posedge clk)
        $past(rst) |-> (!accel && lock_n && !ref_mark && !phase_late));

endmodule

// File: tb/tb_spd_discriminator.sv
`timescale 1ns/1ps
module tb_spd_discriminator;
    localparam int BASE = 64;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ref_tick = 1'b0;
    logic fg_pulse = 1'b0;
    logic short_count = 1'b1;
    logic accel, lock_n, ref_mark, phase_late;

    always #2.5 clk = ~clk;

    spd_discriminator #(.BASE(BASE)) dut (
        .clk(clk), .rst(rst), .ref_tick(ref_tick), .fg_pulse(fg_pulse),
        .short_count(short_count), .accel(accel), .lock_n(lock_n),
        .ref_mark(ref_mark), .phase_late(phase_late)
    );

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;
    string ctx = "R4";

    int refc = 0;
    bit open = 1'b0;
    int tc = 0;
    bit acc_vis = 1'b0, lk_vis = 1'b1, ph_vis = 1'b0, mk_vis = 1'b0;
    bit pend = 1'b0, acc_pend = 1'b0, lk_pend = 1'b1;

    function automatic int tgt(bit s);
        return s ? BASE : 2 * BASE;
    endfunction

    task automatic chk(string req, string nm, logic act, logic exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0b expected=%0b t=%0t", req, nm, act, exp, $time);
        end
    endtask

    task automatic step(bit f, bit t);
        int n, m, d;
        @(negedge clk);
        fg_pulse = f;
        ref_tick = t;
        n = tgt(short_count);
        if (pend) begin
            acc_vis = acc_pend;
            lk_vis  = lk_pend;
            pend    = 1'b0;
        end
        mk_vis = t && (refc >= n - 1);
        if (f) ph_vis = (refc < n / 2);
        if (t) refc = (refc >= n - 1) ? 0 : refc + 1;
        if (!open) begin
            if (f) begin
                open = 1'b1;
                tc = 0;
            end
        end else if (f) begin
            m = tc + (t ? 1 : 0);
            if (m > 2 * n) m = 2 * n;
            d = (m >= n) ? m - n : n - m;
            acc_pend = (m > n);
            lk_pend  = !(d <= n / 16);
            pend     = 1'b1;
            open     = 1'b0;
        end else if (t && tc < 2 * n) begin
            tc++;
        end
        @(posedge clk);
        #1;
        chk($sformatf("%s R4 R7", ctx), "accel", accel, acc_vis);
        chk($sformatf("%s R5 R7", ctx), "lock_n", lock_n, lk_vis);
        chk("R8", "ref_mark", ref_mark, mk_vis);
        chk("R9", "phase_late", phase_late, ph_vis);
    endtask

    // gap g: g-1 quiet cycles then a pulse, ticks with probability dens/4
    task automatic gap(int g, int dens);
        for (int i = 0; i < g - 1; i++) step(1'b0, ($urandom % 4) < dens);
        step(1'b1, ($urandom % 4) < dens);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int n, w;
        void'($urandom(32'd2024));
        repeat (4) @(posedge clk);
        #1;
        chk("R1", "accel", accel, 1'b0);
        chk("R1", "lock_n", lock_n, 1'b1);
        chk("R1", "ref_mark", ref_mark, 1'b0);
        chk("R1", "phase_late", phase_late, 1'b0);
        @(negedge clk);
        rst = 1'b0;

        // short target, dense ticks: window edges (R2 R5)
        short_count = 1'b1;
        n = BASE; w = n / 16;
        ctx = "R2 R3";
        gap(9, 4);
        gap(n, 4);          gap(11, 4);
        ctx = "R5";
        gap(n + w, 4);      gap(13, 4);
        gap(n + w + 1, 4);  gap(5, 4);
        gap(n - w, 4);      gap(7, 4);
        gap(n - w - 1, 4);  gap(3, 4);
        ctx = "R6";
        gap(3 * n, 4);      gap(6, 4);

        // long target (R2)
        short_count = 1'b0;
        n = 2 * BASE; w = n / 16;
        ctx = "R2 R5";
        gap(n + w, 4);      gap(8, 4);
        gap(n - w - 1, 4);  gap(8, 4);
        gap(n, 4);          gap(8, 4);
        ctx = "R6";
        gap(3 * n, 4);      gap(4, 4);

        // sparse ticks (R10) and random target changes
        ctx = "R10 R3";
        for (int i = 0; i < 300; i++) begin
            if ($urandom % 8 == 0) short_count = ~short_count;
            n = tgt(short_count);
            if ($urandom % 20 == 0) gap(3 * n, 4);
            else if ($urandom % 2 == 0) gap(n - n / 8 + int'($urandom % (n / 4 + 1)), 4);
            else gap(4 * n / 3 - n / 6 + int'($urandom % (n / 3 + 1)), 3);
        end
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule